// File: doc/BRIEF.md
# Rotating Interrupt Priority Resolver

This block decides, within the same cycle, whether an interrupt controller should raise its request line and which input line it should present. It takes a vector of raw request bits, a vector of mask bits, a vector of in-service bits and a rotation offset. Priority is circular. The line at the offset position is the most urgent. Urgency then falls step by step around the ring.

The highest-priority unmasked request is compared with the highest-priority in-service line under the same rotation. A grant is issued only when the request strictly outranks every in-service line that counts. Separately, the block reports the most urgent in-service line, which a controller uses to decide which bit a nonspecific end-of-interrupt clears. When a cascade controller runs in special fully nested mode, one in-service bit (the cascade input) can be left out of the grant comparison. Register storage and command decoding live outside this block.

The block is purely combinational. It has no clock, no reset and no handshake, so its outputs are plain level signals that follow the inputs with no latency. No back-pressure rules apply.

Top module: `rot_prio_resolver`

## Requirements
- R1: With offset `o`, the priority level of input line `i` is `(i - o) mod N`. Level 0 is the most urgent. With no in-service bits, `grant_line` is the pending line that has the smallest level.
- R2: A request bit whose `mask_vec` bit is 1 is not pending. It never produces a grant and never displaces a lower-priority unmasked request.
- R3: When no unmasked request exists, `grant_valid` is 0 and `grant_line` is 0.
- R4: A grant occurs only when the pending level is strictly smaller than the level of the most urgent counted in-service bit. An equal level or a larger level gives `grant_valid` 0 and `grant_line` 0. An empty in-service vector counts as level N.
- R5: `svc_valid` is 1 exactly when any `isr_vec` bit is set. `svc_line` is then the set in-service line with the smallest level under the same rotation. With no bit set, both outputs are 0.
- R6: With parameter `HAS_CASCADE`=1 and `nested_en`=1, in-service bit `CASCADE_LINE` (default 2) is ignored in the grant comparison only. A request on that line while its in-service bit is set is then granted. With `nested_en`=0 that bit blocks as any other.
- R7: `svc_valid` and `svc_line` depend only on `isr_vec` and `rot_offset`. They are unaffected by `req_vec`, `mask_vec` and `nested_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_vec | input | N | Raw request bits, one per input line |
| mask_vec | input | N | Mask bits; 1 disables the line's request |
| isr_vec | input | N | In-service bits |
| rot_offset | input | $clog2(N) | Line that holds priority level 0 |
| nested_en | input | 1 | Special fully nested mode: drop the cascade in-service bit from the grant comparison |
| grant_valid | output | 1 | Raise an interrupt |
| grant_line | output | $clog2(N) | Line to present; 0 when no grant |
| svc_valid | output | 1 | Some line is in service |
| svc_line | output | $clog2(N) | Most urgent in-service line; 0 when none |

## Verification
The bench builds the block with its defaults: N=8, cascade exclusion enabled on line 2. At this size every one of the eight rotation offsets can be swept many times with random request, mask and in-service patterns. Exhaustive offsets bring the wrap-around from line 7 to line 0 within reach, along with the equal-level refusal and the cascade exclusion on either side of the offset. Directed cases pin down the empty-vector encodings and show that the in-service report is blind to requests and masks.

// File: rtl/rpr_pkg.sv
package rpr_pkg;

  // Role of each level-finding unit inside the resolver.
  typedef enum int {
    UNIT_PEND = 0,
    UNIT_CUR  = 1,
    UNIT_SVC  = 2
  } unit_e;

  localparam int NUM_UNITS = 3;

  // Circular addition of a level and an offset on a ring of n lines.
  function automatic int wrap_idx(input int lvl, input int ofs, input int n);
    int s;
    s = lvl + ofs;
    if (s >= n) s = s - n;
    return s;
  endfunction

endpackage

// File: rtl/prio_rotator.sv
module prio_rotator #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  input  logic [IDX_W-1:0] ofs,
  output logic [N-1:0]     rot
);
  // rot[k] holds the bit that sits at priority level k.
  always_comb begin
    for (int k = 0; k < N; k++) begin
      logic [IDX_W:0] s;
      s = (IDX_W+1)'(k) + {1'b0, ofs};
      if (s >= (IDX_W+1)'(N)) s = s - (IDX_W+1)'(N);
      rot[k] = vec[s[IDX_W-1:0]];
    end
  end
endmodule

// File: rtl/prio_first.sv
module prio_first #(
  parameter int N     = 8,
  parameter int LVL_W = $clog2(N+1)
) (
  input  logic [N-1:0]     rot,
  output logic [LVL_W-1:0] lvl
);
  // Smallest set position; N when the vector is empty.
  always_comb begin
    lvl = LVL_W'(N);
    for (int k = N-1; k >= 0; k--) begin
      if (rot[k]) lvl = LVL_W'(k);
    end
  end
endmodule

// File: rtl/prio_level_unit.sv
module prio_level_unit #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N),
  parameter int LVL_W = $clog2(N+1)
) (
  input  logic [N-1:0]     vec,
  input  logic [IDX_W-1:0] ofs,
  output logic [LVL_W-1:0] lvl
);
  logic [N-1:0] rot;

  prio_rotator #(.N(N), .IDX_W(IDX_W)) u_rot (
    .vec(vec),
    .ofs(ofs),
    .rot(rot)
  );

  prio_first #(.N(N), .LVL_W(LVL_W)) u_first (
    .rot(rot),
    .lvl(lvl)
  );
endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver
  import rpr_pkg::*;
#(
  parameter int N            = 8,
  parameter bit HAS_CASCADE  = 1'b1,
  parameter int CASCADE_LINE = 2,
  localparam int IDX_W       = $clog2(N),
  localparam int LVL_W       = $clog2(N+1)
) (
  input  logic [N-1:0]     req_vec,
  input  logic [N-1:0]     mask_vec,
  input  logic [N-1:0]     isr_vec,
  input  logic [IDX_W-1:0] rot_offset,
  input  logic             nested_en,
  output logic             grant_valid,
  output logic [IDX_W-1:0] grant_line,
  output logic             svc_valid,
  output logic [IDX_W-1:0] svc_line
);
  logic [N-1:0] excl_mask;
  logic [NUM_UNITS-1:0][N-1:0]     unit_vec;
  logic [NUM_UNITS-1:0][LVL_W-1:0] unit_lvl;

  generate
    if (HAS_CASCADE) begin : g_casc
      always_comb begin
        excl_mask = '0;
        excl_mask[CASCADE_LINE] = nested_en;
      end
    end else begin : g_nocasc
      assign excl_mask = '0;
    end
  endgenerate

  assign unit_vec[UNIT_PEND] = req_vec & ~mask_vec;
  assign unit_vec[UNIT_CUR]  = isr_vec & ~excl_mask;
  assign unit_vec[UNIT_SVC]  = isr_vec;

  generate
    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
      prio_level_unit #(.N(N), .IDX_W(IDX_W), .LVL_W(LVL_W)) u_lvl (
        .vec(unit_vec[g]),
        .ofs(rot_offset),
        .lvl(unit_lvl[g])
      );
    end
  endgenerate

  logic [LVL_W-1:0] pend_lvl, cur_lvl, svc_lvl;
  assign pend_lvl = unit_lvl[UNIT_PEND];
  assign cur_lvl  = unit_lvl[UNIT_CUR];
  assign svc_lvl  = unit_lvl[UNIT_SVC];

  always_comb begin
    grant_valid = (pend_lvl < cur_lvl);
    grant_line  = '0;
    if (grant_valid)
      grant_line = IDX_W'(wrap_idx(int'(pend_lvl), int'(rot_offset), N));
    svc_valid = (svc_lvl != LVL_W'(N));
    svc_line  = '0;
    if (svc_valid)
      svc_line = IDX_W'(wrap_idx(int'(svc_lvl), int'(rot_offset), N));
  end
endmodule

// File: rtl/rot_prio_resolver_chk.sv
module rot_prio_resolver_chk #(
  parameter int N            = 8,
  parameter bit HAS_CASCADE  = 1'b1,
  parameter int CASCADE_LINE = 2,
  localparam int IDX_W       = $clog2(N)
) (
  input logic [N-1:0]     req_vec,
  input logic [N-1:0]     mask_vec,
  input logic [N-1:0]     isr_vec,
  input logic [IDX_W-1:0] rot_offset,
  input logic             nested_en,
  input logic             grant_valid,
  input logic [IDX_W-1:0] grant_line,
  input logic             svc_valid,
  input logic [IDX_W-1:0] svc_line
);
  logic known;
  logic casc_skip;
  assign known = !$isunknown({req_vec, mask_vec, isr_vec, rot_offset, nested_en,
                              grant_valid, grant_line, svc_valid, svc_line});
  assign casc_skip = HAS_CASCADE && nested_en && (int'(grant_line) == CASCADE_LINE);

  always_comb begin
    if (known) begin
      // R2: a granted line is an unmasked request
      p_grant_unmasked_r2: assert (!grant_valid || (req_vec[grant_line] && !mask_vec[grant_line]));
      // R3: nothing pending means no grant
      p_idle_no_grant_r3: assert ((|(req_vec & ~mask_vec)) || (!grant_valid && grant_line == '0));
      // R4: a granted line is not itself in service unless excluded
      p_grant_not_busy_r4: assert (!grant_valid || casc_skip || !isr_vec[grant_line]);
      // R5: in-service report tracks the vector
      p_svc_flag_r5: assert (svc_valid == (|isr_vec));
      p_svc_bit_r5: assert (!svc_valid || isr_vec[svc_line]);
      p_svc_zero_r5: assert (svc_valid || svc_line == '0);
    end
  end
endmodule

bind rot_prio_resolver rot_prio_resolver_chk #(
  .N(N), .HAS_CASCADE(HAS_CASCADE), .CASCADE_LINE(CASCADE_LINE)
) u_chk (
  .req_vec(req_vec), .mask_vec(mask_vec), .isr_vec(isr_vec),
  .rot_offset(rot_offset), .nested_en(nested_en),
  .grant_valid(grant_valid), .grant_line(grant_line),
  .svc_valid(svc_valid), .svc_line(svc_line)
);

// File: tb/rot_prio_resolver_tb.sv
module rot_prio_resolver_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [7:0] req, msk, isr;
  logic [2:0] ofs;
  logic       nen;
  logic       gv, sv;
  logic [2:0] gl, sl;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  rot_prio_resolver u_dut (
    .req_vec(req), .mask_vec(msk), .isr_vec(isr), .rot_offset(ofs),
    .nested_en(nen), .grant_valid(gv), .grant_line(gl),
    .svc_valid(sv), .svc_line(sl)
  );

  function automatic int level_of(input logic [7:0] v, input int o);
    for (int k = 0; k < 8; k++)
      if (v[(k + o) % 8]) return k;
    return 8;
  endfunction

  task automatic compare(input string tag);
    int pl, cl, slv;
    logic [7:0] cv;
    logic ev, esv;
    int el, esl;
    cv = isr;
    if (nen) cv[2] = 1'b0;
    pl  = level_of(req & ~msk, int'(ofs));
    cl  = level_of(cv, int'(ofs));
    slv = level_of(isr, int'(ofs));
    ev  = (pl < cl);
    el  = ev ? (pl + int'(ofs)) % 8 : 0;
    esv = (slv < 8);
    esl = esv ? (slv + int'(ofs)) % 8 : 0;
    n_chk++;
    if (gv !== ev || int'(gl) !== el) begin
      n_bad++;
      $display("FAIL %s grant: got %0b/%0d expected %0b/%0d (req=%h msk=%h isr=%h ofs=%0d nen=%0b)",
               tag, gv, gl, ev, el, req, msk, isr, ofs, nen);
    end
    n_chk++;
    if (sv !== esv || int'(sl) !== esl) begin
      n_bad++;
      $display("FAIL %s service: got %0b/%0d expected %0b/%0d (isr=%h ofs=%0d)",
               tag, sv, sl, esv, esl, isr, ofs);
    end
  endtask

  task automatic apply(input logic [7:0] r, input logic [7:0] m, input logic [7:0] s,
                       input logic [2:0] o, input logic n, input string tag);
    @(posedge clk);
    req = r; msk = m; isr = s; ofs = o; nen = n;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic expect_line(input string tag, input logic v, input logic [2:0] l,
                             input logic ev, input logic [2:0] el);
    n_chk++;
    if (v !== ev || l !== el) begin
      n_bad++;
      $display("FAIL %s: got %0b/%0d expected %0b/%0d", tag, v, l, ev, el);
    end
  endtask

  initial begin
    req = '0; msk = '0; isr = '0; ofs = '0; nen = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare("R3 reset idle");
    expect_line("R3 idle grant", gv, gl, 1'b0, 3'd0);
    expect_line("R5 idle service", sv, sl, 1'b0, 3'd0);
    // R1: offset 5, lines 0 and 4 pending; line 0 is level 3, line 4 level 7
    apply(8'h11, 8'h00, 8'h00, 3'd5, 1'b0, "R1 rotation");
    expect_line("R1 rotation", gv, gl, 1'b1, 3'd0);
    // R1: wrap past line 7
    apply(8'h81, 8'h00, 8'h00, 3'd1, 1'b0, "R1 wrap");
    expect_line("R1 wrap", gv, gl, 1'b1, 3'd7);
    // R2: masked higher line skipped
    apply(8'h03, 8'h01, 8'h00, 3'd0, 1'b0, "R2 mask");
    expect_line("R2 mask", gv, gl, 1'b1, 3'd1);
    apply(8'h03, 8'h03, 8'h00, 3'd0, 1'b0, "R3 all masked");
    expect_line("R3 all masked", gv, gl, 1'b0, 3'd0);
    // R4: equal level refused, higher level granted
    apply(8'h08, 8'h00, 8'h08, 3'd0, 1'b0, "R4 equal");
    expect_line("R4 equal", gv, gl, 1'b0, 3'd0);
    apply(8'h04, 8'h00, 8'h08, 3'd0, 1'b0, "R4 outrank");
    expect_line("R4 outrank", gv, gl, 1'b1, 3'd2);
    apply(8'h10, 8'h00, 8'h08, 3'd0, 1'b0, "R4 lower");
    expect_line("R4 lower", gv, gl, 1'b0, 3'd0);
    // R6: cascade in-service bit excluded only in nested mode
    apply(8'h04, 8'h00, 8'h04, 3'd0, 1'b1, "R6 nested on");
    expect_line("R6 nested on", gv, gl, 1'b1, 3'd2);
    expect_line("R6 service keeps bit", sv, sl, 1'b1, 3'd2);
    apply(8'h04, 8'h00, 8'h04, 3'd0, 1'b0, "R6 nested off");
    expect_line("R6 nested off", gv, gl, 1'b0, 3'd0);
    // R7: service report blind to requests, masks, nested mode
    apply(8'hFF, 8'hFF, 8'h30, 3'd5, 1'b1, "R7 service");
    expect_line("R7 service", sv, sl, 1'b1, 3'd5);
    apply(8'h00, 8'h00, 8'h30, 3'd5, 1'b0, "R7 service");
    expect_line("R7 service", sv, sl, 1'b1, 3'd5);
    // R5: service level follows rotation
    apply(8'h00, 8'h00, 8'h30, 3'd6, 1'b0, "R5 rotate");
    expect_line("R5 rotate", sv, sl, 1'b1, 3'd4);
    // Sweep all offsets with random patterns (R1, R4, R6)
    for (int o = 0; o < 8; o++) begin
      for (int t = 0; t < 400; t++) begin
        logic [7:0] r, m, s;
        r = 8'($urandom); m = 8'($urandom) & 8'($urandom);
        s = 8'($urandom) & 8'($urandom) & 8'($urandom);
        apply(r, m, s, 3'(o), 1'($urandom), "R1 sweep");
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule